// File: doc/BRIEF.md
# SDRAM Low-Power Entry Sequencer

This block lives inside an SDRAM controller and takes over the memory command pins when the memory must keep its contents without normal service. Two events start it: a system reset that does not also reset the controller, and a low-power request raised by the bus masters. When either event is seen, the block waits until no bus access is in flight. It then closes every open row with a precharge-all command and waits the programmed precharge time. After that it puts the memory into one of two retention states. If refresh is enabled, it issues self-refresh with clock enable low. If refresh is not enabled, it drops clock enable with a no-operation command, which is powerdown. Only once the memory is in that state does it tell the system clock controller that sleep is safe.

Refresh counts as enabled only after a nonzero refresh rate has been written since the last controller-local reset. The mode is captured when precharge-all is issued and holds for the rest of that sequence. When both triggers are released, the block raises clock enable and drops the sleep-ready flag. It then waits an exit delay and hands the command pins back to the normal command path. The exit delay is the programmed self-refresh exit time after self-refresh, and one cycle after powerdown. A busy output is high for the whole sequence so that the surrounding controller stalls new requests.

Top module: `sdram_lp_sequencer`

## Requirements
- R1: The retention mode is chosen when precharge-all is issued. If refresh is enabled at that moment, the entry cycle carries the self-refresh command. Otherwise the entry cycle carries a no-operation command, which is powerdown. In both cases clock enable is low in the entry cycle.
- R2: Refresh enable is cleared by the controller-local reset `rst_n`. A rate write with a nonzero value sets it, and a rate write with value zero clears it.
- R3: A high level on `sys_reset_i` or `lp_req_i` seen in the idle state starts the sequence. Precharge-all is issued no earlier than the cycle after `bus_active_i` is first seen low. It is never issued while `bus_active_i` stays high.
- R4: Precharge-all is driven for exactly one cycle, as cs_n=0, ras_n=0, cas_n=1, we_n=0 with a10=1. Self-refresh is driven as cs_n=0, ras_n=0, cas_n=0, we_n=1. Precharge-all always comes before the entry cycle.
- R5: The entry cycle comes max(trp_cycles_i,1)+1 cycles after the precharge-all cycle. No-operation is driven on the cycles in between.
- R6: `sleep_ready_o` is high from the cycle after entry until a release of the triggers is seen. Clock enable is low for that whole time.
- R7: When both triggers are seen low in the low-power state, the next cycle has clock enable high and `sleep_ready_o` low. Exit then lasts max(txsr_cycles_i,1) cycles after self-refresh, or 1 cycle after powerdown, and the block then returns to idle.
- R8: Every cycle that is neither precharge-all nor self-refresh drives no-operation: cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0.
- R9: `busy_o` is low in idle and after reset. It is high from the cycle after a trigger is seen until exit completes.
- R10: A rate write made during a sequence, after precharge-all has been issued, does not change the retention mode of that sequence. It does take effect for the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller-local asynchronous reset, active low |
| sys_reset_i | input | 1 | System reset seen without a controller-local reset |
| lp_req_i | input | 1 | Low-power request from the bus masters |
| bus_active_i | input | 1 | A bus access is in progress |
| rate_wr_i | input | 1 | Write strobe of the refresh-rate value |
| rate_wdata_i | input | RATE_W | Refresh-rate value being written |
| trp_cycles_i | input | CNT_W | Precharge time in cycles |
| txsr_cycles_i | input | CNT_W | Self-refresh exit time in cycles |
| busy_o | output | 1 | Sequence in progress; block owns the command pins |
| cke_o | output | 1 | Memory clock enable |
| sleep_ready_o | output | 1 | Memory is in retention; system may sleep |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10; high selects all banks for precharge |

## Verification
Each output is a decode of registered state. A trigger level present at an edge therefore shows as busy in the next cycle. Precharge-all appears one cycle after `bus_active_i` is first seen low, and entry appears max(tRP,1)+1 cycles after precharge-all. Sleep-ready follows entry by one cycle, and clock enable rises one cycle after the release is seen. The bench keeps a behavioural model that advances on every rising edge from the same input values the design sees. It compares every output on the falling edge, half a cycle after the edge that produced it, so each result is checked in exactly the cycle it is due. Scenarios cover a held bus, zero and nonzero timing values, rate writes that enable and disable refresh, a rate write in mid-sequence, a local reset, and overlapping triggers.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_ENTER,
        ST_LOWPOWER,
        ST_EXIT
    } lp_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PALL,
        CMD_SREF
    } lp_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } cmd_pins_t;

endpackage

// File: rtl/sdram_lp_refen.sv
module sdram_lp_refen #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    output logic              refen_o
);
    logic refen_d, refen_q;

    always_comb begin
        refen_d = refen_q;
        if (rate_wr_i) refen_d = (rate_wdata_i != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) refen_q <= 1'b0;
        else        refen_q <= refen_d;
    end

    assign refen_o = refen_q;

    // R2
    refen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_wr_i |=> $stable(refen_q));

endmodule

// File: rtl/sdram_lp_timer.sv
module sdram_lp_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = (val_i == '0) ? CNT_W'(1) : val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CNT_W'(1));

    // R5
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q != '0));

endmodule

// File: rtl/sdram_lp_cmdenc.sv
module sdram_lp_cmdenc
    import sdram_lp_pkg::*;
(
    input  lp_cmd_e   cmd_i,
    output cmd_pins_t pins_o
);
    always_comb begin
        unique case (cmd_i)
            CMD_PALL: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
            CMD_SREF: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
            default:  pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
        endcase
    end
endmodule

// File: rtl/sdram_lp_sequencer.sv
module sdram_lp_sequencer
    import sdram_lp_pkg::*;
#(
    parameter int RATE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset_i,
    input  logic              lp_req_i,
    input  logic              bus_active_i,
    input  logic              rate_wr_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    input  logic [CNT_W-1:0]  trp_cycles_i,
    input  logic [CNT_W-1:0]  txsr_cycles_i,
    output logic              busy_o,
    output logic              cke_o,
    output logic              sleep_ready_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              a10_o
);
    typedef struct packed {
        lp_state_e st;
        logic      sr;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             refen;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             trig;
    lp_cmd_e          cmd;
    cmd_pins_t        pins;

    sdram_lp_refen #(.RATE_W(RATE_W)) u_refen (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_wr_i    (rate_wr_i),
        .rate_wdata_i (rate_wdata_i),
        .refen_o      (refen)
    );

    sdram_lp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    assign trig = sys_reset_i | lp_req_i;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.st)
            ST_IDLE:      if (trig) seq_d.st = ST_WAIT_BUS;
            ST_WAIT_BUS:  if (!bus_active_i) seq_d.st = ST_PRECHARGE;
            ST_PRECHARGE: begin
                seq_d.sr = refen;
                tmr_load = 1'b1;
                tmr_val  = trp_cycles_i;
                seq_d.st = ST_WAIT_RP;
            end
            ST_WAIT_RP:   if (tmr_last) seq_d.st = ST_ENTER;
            ST_ENTER:     seq_d.st = ST_LOWPOWER;
            ST_LOWPOWER:  if (!trig) begin
                tmr_load = 1'b1;
                tmr_val  = seq_q.sr ? txsr_cycles_i : CNT_W'(1);
                seq_d.st = ST_EXIT;
            end
            ST_EXIT:      if (tmr_last) seq_d.st = ST_IDLE;
            default:      seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, sr: 1'b0};
        else        seq_q <= seq_d;
    end

    always_comb begin
        cmd = CMD_NOP;
        if (seq_q.st == ST_PRECHARGE)            cmd = CMD_PALL;
        else if (seq_q.st == ST_ENTER && seq_q.sr) cmd = CMD_SREF;
    end

    sdram_lp_cmdenc u_enc (
        .cmd_i  (cmd),
        .pins_o (pins)
    );

    assign busy_o        = (seq_q.st != ST_IDLE);
    assign cke_o         = !(seq_q.st == ST_ENTER || seq_q.st == ST_LOWPOWER);
    assign sleep_ready_o = (seq_q.st == ST_LOWPOWER);
    assign cs_n_o        = pins.cs_n;
    assign ras_n_o       = pins.ras_n;
    assign cas_n_o       = pins.cas_n;
    assign we_n_o        = pins.we_n;
    assign a10_o         = pins.a10;

    // R6
    sleep_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ready_o |-> !cke_o);

    // R3
    bus_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT_BUS && bus_active_i) |=> (seq_q.st == ST_WAIT_BUS));

    // R4
    pall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ENTER) |-> ($past(seq_q.st) == ST_WAIT_RP));

    // R9
    sleep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ready_o |-> busy_o);

    // R7
    exit_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_ready_o) |-> cke_o);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT_RP || seq_q.st == ST_ENTER || seq_q.st == ST_LOWPOWER)
        |=> $stable(seq_q.sr));

endmodule

// File: tb/sdram_lp_sequencer_test.sv
module sdram_lp_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int RATE_W     = 16;
    localparam int CNT_W      = 8;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sys_reset_i = 1'b0;
    logic              lp_req_i = 1'b0;
    logic              bus_active_i = 1'b0;
    logic              rate_wr_i = 1'b0;
    logic [RATE_W-1:0] rate_wdata_i = '0;
    logic [CNT_W-1:0]  trp_cycles_i = 8'd3;
    logic [CNT_W-1:0]  txsr_cycles_i = 8'd5;
    logic busy_o, cke_o, sleep_ready_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, a10_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_lp_sequencer #(.RATE_W(RATE_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .sys_reset_i(sys_reset_i), .lp_req_i(lp_req_i),
        .bus_active_i(bus_active_i), .rate_wr_i(rate_wr_i), .rate_wdata_i(rate_wdata_i),
        .trp_cycles_i(trp_cycles_i), .txsr_cycles_i(txsr_cycles_i),
        .busy_o(busy_o), .cke_o(cke_o), .sleep_ready_o(sleep_ready_o),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .a10_o(a10_o)
    );

    // Behavioural reference: phase 0 idle, 1 waiting for bus, 2 precharge,
    // 3 precharge wait, 4 entry, 5 retained, 6 leaving.
    int    ph = 0;
    int    cnt = 0;
    bit    m_sr = 0;
    bit    m_ren = 0;
    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string scen = "R9 reset";

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; m_sr = 0; m_ren = 0;
        end else begin
            case (ph)
                0: if (sys_reset_i || lp_req_i) ph = 1;
                1: if (!bus_active_i) ph = 2;
                2: begin m_sr = m_ren; cnt = (trp_cycles_i == 0) ? 1 : int'(trp_cycles_i); ph = 3; end
                3: begin cnt--; if (cnt == 0) ph = 4; end
                4: ph = 5;
                5: if (!(sys_reset_i || lp_req_i)) begin
                       cnt = m_sr ? ((txsr_cycles_i == 0) ? 1 : int'(txsr_cycles_i)) : 1;
                       ph = 6;
                   end
                6: begin cnt--; if (cnt == 0) ph = 0; end
                default: ph = 0;
            endcase
            if (rate_wr_i) m_ren = (rate_wdata_i != 0);
        end
    end

    task automatic chk(string nm, int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s | %s] t=%0t actual=%0d expected=%0d", nm, tag, scen, $time, act, exp);
        end
    endtask

    function automatic string ph_tag(int p);
        case (p)
            0: return "R8 R9";
            1: return "R3";
            2: return "R4";
            3: return "R5 R8";
            4: return "R1 R4";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
        if (chk_on) begin
            string tg;
            bit e_pall, e_sref;
            tg = ph_tag(ph);
            e_pall = (ph == 2);
            e_sref = (ph == 4) && m_sr;
            chk("busy",  busy_o,        ph != 0,                     tg);
            chk("cke",   cke_o,         !(ph == 4 || ph == 5),        tg);
            chk("sleep", sleep_ready_o, ph == 5,                     tg);
            chk("cs_n",  cs_n_o,        0,                           tg);
            chk("ras_n", ras_n_o,       !(e_pall || e_sref),         tg);
            chk("cas_n", cas_n_o,       !e_sref,                     tg);
            chk("we_n",  we_n_o,        !e_pall,                     tg);
            chk("a10",   a10_o,         e_pall,                      tg);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_rate(int v);
        rate_wr_i = 1'b1; rate_wdata_i = RATE_W'(v);
        tick(1);
        rate_wr_i = 1'b0;
    endtask

    initial begin
        tick(3);
        chk_on = 1;
        tick(1);
        rst_n = 1'b1;
        tick(2);

        // R1 R3: powerdown via low-power request while bus is held
        scen = "R1 R3 powerdown, bus held";
        bus_active_i = 1'b1; lp_req_i = 1'b1;
        tick(5);
        bus_active_i = 1'b0;
        tick(12);
        lp_req_i = 1'b0;
        tick(6);

        // R2: nonzero rate enables self-refresh, system reset as trigger
        scen = "R2 R1 self-refresh on system reset";
        write_rate(100);
        sys_reset_i = 1'b1;
        tick(15);
        sys_reset_i = 1'b0;
        tick(10);

        // R5 R7: zero timing values clamp to one cycle
        scen = "R5 R7 zero tRP and tXSR";
        trp_cycles_i = 8'd0; txsr_cycles_i = 8'd0;
        lp_req_i = 1'b1;
        tick(10);
        lp_req_i = 1'b0;
        tick(5);

        // R10: rate write of zero after precharge keeps self-refresh
        scen = "R10 mode held mid-sequence";
        trp_cycles_i = 8'd4; txsr_cycles_i = 8'd3;
        lp_req_i = 1'b1;
        tick(3);
        write_rate(0);
        tick(10);
        lp_req_i = 1'b0;
        tick(6);

        // R2: zero write took effect for the next sequence
        scen = "R2 zero rate gives powerdown";
        lp_req_i = 1'b1;
        tick(10);
        lp_req_i = 1'b0;
        tick(5);

        // R2: local reset clears a previously set enable
        scen = "R2 local reset clears enable";
        write_rate(7);
        tick(1);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        sys_reset_i = 1'b1;
        tick(10);
        sys_reset_i = 1'b0;
        tick(5);

        // R7: retention holds while either trigger stays high
        scen = "R7 overlapping triggers";
        write_rate(9);
        trp_cycles_i = 8'd2; txsr_cycles_i = 8'd4;
        sys_reset_i = 1'b1; lp_req_i = 1'b1;
        tick(10);
        lp_req_i = 1'b0;
        tick(5);
        sys_reset_i = 1'b0;
        tick(8);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule